// File: doc/BRIEF.md
# SECDED Protected Memory with 72/64 Codec

This block keeps 64-bit data words safe against bit flips in storage by adding eight check bits to every word. A write stores the 72-bit codeword built from the incoming data in an internal array with one write port and one read port. A read decodes the stored codeword, repairs any one flipped bit, flags any two flipped bits, and reports the syndrome alongside the data one clock after the read request.

The same encoder and decoder also serve a memory outside the block. The codeword for the current write data is always present on an output, so an external 72-bit memory can store it. A read with the external-source select raised decodes a codeword supplied on an input instead of an array word, through the same registered result path. Reading and writing one array address in the same cycle is not permitted; the result of such a read is undefined.

Top module: `ecc_sdp_mem`

## Requirements
- R1: `codeOut` is, without a clock, the codeword of `wrData`: the 64 data bits sit in ascending order at positions 3,5,6,7,9,...,71 (every position from 1 to 71 that is not a power of two), check bits sit at positions 1,2,4,8,16,32,64 so that the XOR of the indices of all set bits in positions 1..71 is zero, and bit 0 makes the total count of ones in all 72 bits even.
- R2: A read request (`rdEn`) sampled at a rising edge produces its result after that edge, with `rdValid` high for exactly the one following cycle per request.
- R3: A read of an error-free codeword returns the written data with both flags low and `syndrome` zero.
- R4: With one bit flipped at a data position p, the read returns the original data, raises `singleErr` only, and reports `syndrome` = {1, p[6:0]}.
- R5: With one bit flipped at bit 0 or at a check-bit position p, the data is unchanged, `singleErr` is high, and `syndrome` = {1, p[6:0]} (p = 0 for bit 0).
- R6: With two bits p and q flipped, `doubleErr` is high, `singleErr` low, `syndrome` = {0, p XOR q}, and the data bits are returned exactly as received, uncorrected.
- R7: An odd error pattern whose 7-bit syndrome exceeds 71 is reported as uncorrectable: `doubleErr` high, `singleErr` low, `syndrome` = {1, s}, data uncorrected.
- R8: With `rdExt` high, the read decodes `extCode` and leaves the array contents untouched.
- R9: In a cycle with `rdValid` low, both flags and `syndrome` are zero and `rdData` keeps its last value.
- R10: After reset, `rdValid`, both flags, `syndrome` and `rdData` are zero.
- R11: A write and an array read to different addresses in one cycle both take effect: the read returns the word stored before the edge, the write is seen by later reads; the same address in both is not allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Store codeword of `wrData` at `wrAddr` |
| wrAddr | input | ADDR_W | Array write address |
| wrData | input | 64 | Data word to protect |
| codeOut | output | 72 | Codeword of `wrData` for external storage |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W | Array read address |
| rdExt | input | 1 | Decode `extCode` instead of the array word |
| extCode | input | 72 | Codeword read from an external memory |
| rdData | output | 64 | Decoded data |
| rdValid | output | 1 | Result of a read is present this cycle |
| singleErr | output | 1 | One bit error was corrected |
| doubleErr | output | 1 | Uncorrectable error detected |
| syndrome | output | 8 | {overall parity mismatch, 7-bit position syndrome} |

## Verification
The bench flips the overall parity bit alone, a check bit alone, the highest data position and a low data position, expecting correction in each; a decoder that mixed up check and data positions would corrupt data on a check-bit error, and one that ignored bit 0 would miss that flip. Two-bit patterns including bit 0 must be flagged without any correction, since a design that trusted the nonzero syndrome would flip an innocent bit. A three-bit pattern whose syndrome points past position 71 must be reported as uncorrectable rather than silently accepted. Concurrent write and read to different addresses, and external reads followed by array read-back, catch a read path that sees the new word too early or an external read that disturbs the array.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  localparam int DATA_W = 64;
  localparam int POS_W  = 7;
  localparam int CODE_W = 72;
  localparam int SYN_W  = POS_W + 1;

  typedef struct packed {
    logic wr;
    logic rd;
    logic ext;
  } ecc_stb_t;

  function automatic logic isPow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  function automatic logic [POS_W-1:0] posSyndrome(input logic [CODE_W-1:0] c);
    logic [POS_W-1:0] s;
    s = '0;
    for (int b = 0; b < POS_W; b++) begin
      for (int p = 1; p < CODE_W; p++) begin
        if (((p >> b) & 1) != 0) s[b] = s[b] ^ c[p];
      end
    end
    return s;
  endfunction

  function automatic logic [CODE_W-1:0] encodeWord(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    logic [POS_W-1:0]  s;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!isPow2(p)) begin
        c[p] = d[k];
        k++;
      end
    end
    s = posSyndrome(c);
    for (int b = 0; b < POS_W; b++) c[1 << b] = s[b];
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] extractData(input logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!isPow2(p)) begin
        d[k] = c[p];
        k++;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
  import ecc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  input  logic     rdEn,
  input  logic     rdExt,
  output ecc_stb_t stb,
  output logic     rdValid
);

  always_comb begin
    stb.wr  = wrEn;
    stb.rd  = rdEn;
    stb.ext = rdExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= rdEn;
  end

endmodule

// File: rtl/ecc_datapath.sv
module ecc_datapath
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ecc_stb_t          stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [CODE_W-1:0] codeOut,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [CODE_W-1:0] extCode,
  output logic [DATA_W-1:0] rdData,
  output logic              singleErr,
  output logic              doubleErr,
  output logic [SYN_W-1:0]  syndrome
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int LAST_POS = CODE_W - 1;

  logic [CODE_W-1:0] memArr [DEPTH];
  logic [CODE_W-1:0] rdCode;
  logic [CODE_W-1:0] fixCode;
  logic [POS_W-1:0]  synRaw;
  logic              parMis;
  logic              decSingle;
  logic              decDouble;
  logic [DATA_W-1:0] decData;

  always_comb codeOut = encodeWord(wrData);

  always_ff @(posedge clk) begin
    if (stb.wr) memArr[wrAddr] <= codeOut;
  end

  always_comb begin
    rdCode = stb.ext ? extCode : memArr[rdAddr];
    synRaw = posSyndrome(rdCode);
    parMis = ^rdCode;
  end

  always_comb begin
    fixCode   = rdCode;
    decSingle = 1'b0;
    decDouble = 1'b0;
    if (parMis) begin
      if (synRaw <= POS_W'(LAST_POS)) begin
        decSingle = 1'b1;
        for (int p = 1; p < CODE_W; p++) begin
          if (synRaw == POS_W'(p)) fixCode[p] = ~rdCode[p];
        end
      end else begin
        decDouble = 1'b1;
      end
    end else if (synRaw != '0) begin
      decDouble = 1'b1;
    end
    decData = extractData(fixCode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData    <= '0;
      singleErr <= 1'b0;
      doubleErr <= 1'b0;
      syndrome  <= '0;
    end else if (stb.rd) begin
      rdData    <= decData;
      singleErr <= decSingle;
      doubleErr <= decDouble;
      syndrome  <= {parMis, synRaw};
    end else begin
      singleErr <= 1'b0;
      doubleErr <= 1'b0;
      syndrome  <= '0;
    end
  end

endmodule

// File: rtl/ecc_sdp_mem.sv
module ecc_sdp_mem
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [63:0]       wrData,
  output logic [71:0]       codeOut,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdExt,
  input  logic [71:0]       extCode,
  output logic [63:0]       rdData,
  output logic              rdValid,
  output logic              singleErr,
  output logic              doubleErr,
  output logic [7:0]        syndrome
);

  ecc_stb_t stb;

  ecc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .rdExt   (rdExt),
    .stb     (stb),
    .rdValid (rdValid)
  );

  ecc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .codeOut   (codeOut),
    .rdAddr    (rdAddr),
    .extCode   (extCode),
    .rdData    (rdData),
    .singleErr (singleErr),
    .doubleErr (doubleErr),
    .syndrome  (syndrome)
  );

endmodule

// File: rtl/ecc_sdp_mem_chk.sv
module ecc_sdp_mem_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdExt,
  input logic [71:0]       codeOut,
  input logic [63:0]       rdData,
  input logic              rdValid,
  input logic              singleErr,
  input logic              doubleErr,
  input logic [7:0]        syndrome
);

  a_r1_code_even: assert property (@(posedge clk) disable iff (!rstN)
    (^codeOut) == 1'b0);

  a_r2_valid_follows_rd: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  a_r2_valid_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(singleErr && doubleErr));

  a_r4_single_marks_parity: assert property (@(posedge clk) disable iff (!rstN)
    singleErr |-> syndrome[7]);

  a_r7_double_nonzero_syn: assert property (@(posedge clk) disable iff (!rstN)
    doubleErr |-> (syndrome[6:0] != 7'd0));

  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (!singleErr && !doubleErr && syndrome == 8'd0));

  a_r9_data_holds: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  a_r11_no_same_addr: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn && !rdExt) |-> (wrAddr != rdAddr));

endmodule

bind ecc_sdp_mem ecc_sdp_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .rdExt     (rdExt),
  .codeOut   (codeOut),
  .rdData    (rdData),
  .rdValid   (rdValid),
  .singleErr (singleErr),
  .doubleErr (doubleErr),
  .syndrome  (syndrome)
);

// File: tb/ecc_sdp_mem_tb.sv
module ecc_sdp_mem_tb;

  localparam int AW = 4;

  typedef struct packed {
    logic [63:0] d;
    logic [7:0]  f1;
    logic [7:0]  f2;
    logic [7:0]  f3;
  } vec_t;

  localparam logic [7:0] NO = 8'hFF;

  localparam vec_t VECS [10] = '{
    '{64'h0123_4567_89AB_CDEF, NO,    NO,    NO   },
    '{64'hFFFF_FFFF_FFFF_FFFF, 8'd3,  NO,    NO   },
    '{64'hA5A5_5A5A_0F0F_F0F0, 8'd71, NO,    NO   },
    '{64'h0000_0000_0000_0001, 8'd16, NO,    NO   },
    '{64'hDEAD_BEEF_CAFE_F00D, 8'd0,  NO,    NO   },
    '{64'h5555_5555_5555_5555, 8'd64, NO,    NO   },
    '{64'h1357_9BDF_2468_ACE0, 8'd5,  8'd70, NO   },
    '{64'h8000_0000_0000_0000, 8'd0,  8'd33, NO   },
    '{64'hFEDC_BA98_7654_3210, 8'd64, 8'd12, 8'd0 },
    '{64'h0F1E_2D3C_4B5A_6978, 8'd2,  8'd1,  NO   }
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [63:0]   wrData = '0;
  logic [71:0]   codeOut;
  logic          rdEn = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic          rdExt = 1'b0;
  logic [71:0]   extCode = '0;
  logic [63:0]   rdData;
  logic          rdValid;
  logic          singleErr;
  logic          doubleErr;
  logic [7:0]    syndrome;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #5 clk = ~clk;

  ecc_sdp_mem #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .codeOut(codeOut), .rdEn(rdEn), .rdAddr(rdAddr), .rdExt(rdExt),
    .extCode(extCode), .rdData(rdData), .rdValid(rdValid),
    .singleErr(singleErr), .doubleErr(doubleErr), .syndrome(syndrome)
  );

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  function automatic logic [63:0] dataOf(input logic [71:0] c);
    logic [63:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p < 72; p++) if (!pow2(p)) begin d[k] = c[p]; k++; end
    return d;
  endfunction

  function automatic logic [6:0] indexXor(input logic [71:0] c);
    logic [6:0] x;
    x = '0;
    for (int p = 1; p < 72; p++) if (c[p]) x = x ^ 7'(p);
    return x;
  endfunction

  task automatic readOne(input logic ext, input logic [AW-1:0] a, input logic [71:0] code);
    @(negedge clk);
    rdEn = 1'b1; rdExt = ext; rdAddr = a; extCode = code;
    @(negedge clk);
    rdEn = 1'b0; rdExt = 1'b0;
  endtask

  task automatic writeOne(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog R2 actual=hang expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset outputs", {15'd0, rdValid, singleErr, doubleErr, syndrome, rdData}, 80'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector table over the external path
    for (int i = 0; i < 10; i++) begin
      logic [71:0] code, bad;
      logic [6:0]  synE;
      int          n;
      logic        mis, expS, expD;
      logic [63:0] expData;
      wrData = VECS[i].d;
      @(negedge clk);
      code = codeOut;
      chk("R1 data placement", {16'd0, dataOf(code)}, {16'd0, VECS[i].d});
      chk("R1 check bits", {73'd0, indexXor(code)}, 80'd0);
      chk("R1 overall parity", {79'd0, ^code}, 80'd0);
      bad = code; synE = '0; n = 0;
      if (VECS[i].f1 != NO) begin bad[VECS[i].f1] = ~bad[VECS[i].f1]; synE ^= VECS[i].f1[6:0]; n++; end
      if (VECS[i].f2 != NO) begin bad[VECS[i].f2] = ~bad[VECS[i].f2]; synE ^= VECS[i].f2[6:0]; n++; end
      if (VECS[i].f3 != NO) begin bad[VECS[i].f3] = ~bad[VECS[i].f3]; synE ^= VECS[i].f3[6:0]; n++; end
      mis  = n[0];
      expS = mis && (synE <= 7'd71);
      expD = (mis && (synE > 7'd71)) || (!mis && synE != 7'd0);
      expData = expD ? dataOf(bad) : VECS[i].d;
      readOne(1'b1, '0, bad);
      // R3 clean, R4 data bit, R5 check/parity bit, R6 double, R7 beyond range
      chk("R2 rdValid after read", {79'd0, rdValid}, 80'd1);
      chk("R3/R4/R5/R6/R7 data", {16'd0, rdData}, {16'd0, expData});
      chk("R4/R5/R6/R7 flags and syndrome", {70'd0, singleErr, doubleErr, syndrome},
          {70'd0, expS, expD, mis, synE});
      @(negedge clk);
      chk("R2 rdValid one cycle", {79'd0, rdValid}, 80'd0);
      chk("R9 idle flags zero", {70'd0, singleErr, doubleErr, syndrome}, 80'd0);
      chk("R9 data holds", {16'd0, rdData}, {16'd0, expData});
    end

    // R2 R3: internal array write then read back
    for (int a = 0; a < 4; a++) writeOne(AW'(a), {16'h1000 + 16'(a), 48'hABC_0000_1234} ^ 64'(a * 977));
    for (int a = 0; a < 4; a++) begin
      readOne(1'b0, AW'(a), '0);
      chk("R3 array read data", {16'd0, rdData}, {16'd0, {16'h1000 + 16'(a), 48'hABC_0000_1234} ^ 64'(a * 977)});
      chk("R3 array read clean", {70'd0, singleErr, doubleErr, syndrome}, 80'd0);
    end

    // R11: write addr 5 while reading addr 1 in the same cycle
    writeOne(AW'(5), 64'h1111_2222_3333_4444);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(5); wrData = 64'h9999_8888_7777_6666;
    rdEn = 1'b1; rdAddr = AW'(5 - 4);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    chk("R11 concurrent read data", {16'd0, rdData}, {16'd0, {16'h1001, 48'hABC_0000_1234} ^ 64'(977)});
    readOne(1'b0, AW'(5), '0);
    chk("R11 write took effect", {16'd0, rdData}, {16'd0, 64'h9999_8888_7777_6666});
    // R11: read old word while overwriting a different address
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(2); wrData = 64'h0;
    rdEn = 1'b1; rdAddr = AW'(5);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    chk("R11 read during other write", {16'd0, rdData}, {16'd0, 64'h9999_8888_7777_6666});

    // R8: external read with garbage does not disturb the array
    readOne(1'b1, AW'(0), 72'hFF_FFFF_0000_FFFF_0000);
    readOne(1'b0, AW'(0), '0);
    chk("R8 array untouched", {16'd0, rdData}, {16'd0, {16'h1000, 48'hABC_0000_1234}});
    chk("R8 array clean", {70'd0, singleErr, doubleErr, syndrome}, 80'd0);

    // R10: reset mid-run clears outputs
    readOne(1'b1, '0, 72'h1);
    rstN = 1'b0;
    @(negedge clk);
    chk("R10 reset clears", {15'd0, rdValid, singleErr, doubleErr, syndrome, rdData}, 80'd0);
    rstN = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule